// File: doc/BRIEF.md
# Two-Channel Multi-Format Serial Audio Transmitter

This block is the clock-master end of a stereo serial audio link. It runs from one fast clock, `clk`, which is taken to be twice the reference clock. From `clk` it generates a bit clock, a word clock and one serial data line. Each frame carries one left sample and then one right sample. A frame is always 64 bit clocks long, split into two 32-bit slots.

A 2-bit code selects the framing and another 2-bit code selects the word length. Both codes, and the stereo pair, are taken only at a frame boundary. A one-cycle ready strobe marks that boundary. If the source presents a valid pair during the strobe, the pair is captured. If it does not, the previous pair is sent again.

Framing codes: 00 left-justified, 01 I2S, 10 TDM, 11 right-justified. Word-length codes: 00 = 24 bits, 01 = 20, 10 = 18, 11 = 16. Samples arrive as 24-bit words with the MSB at bit 23. A shorter word keeps the upper bits and drops the low-order ones.

Top module: `audio_serial_tx`

## Requirements
- R1: Word-clock shape. A frame spans 64 bit-clock periods. With framing 00, 10 or 11, `wclk_o` is high for the first 32 bits (left slot) and low for the last 32 (right slot). With framing 01 it is low for the first 32 and high for the last 32. `wclk_o` only toggles in the cycle where `bclk_o` falls.
- R2: Framing 00 (left-justified) puts the sample MSB in bit 0 of its slot, then sends lower bits MSB-first.
- R3: Framing 01 (I2S) puts the sample MSB in bit 1 of its slot, one bit clock after the word-clock edge.
- R4: Framing 11 (right-justified) puts the sample LSB in bit 31 of its slot. Bits before the sample are 0.
- R5: Framing 10 (TDM) runs `bclk_o` at the reference rate, which is a period of 2 `clk` cycles. The left slot starts with the frame pulse and the right slot follows at bit 32. Each sample is sent MSB-first from its slot's first bit.
- R6: With framings 00, 01 and 11, `bclk_o` has a period of 2×BCLK_HALF `clk` cycles. It is low for the first half of each bit and high for the second half.
- R7: Word-length codes 00/01/10/11 send 24/20/18/16 bits. The bits sent are the upper bits of the 24-bit input, MSB first. Every slot position not carrying a sample bit is 0.
- R8: `sdata_o` and `wclk_o` only change in the cycle where `bclk_o` falls. They hold steady while `bclk_o` stays low or stays high.
- R9: `pair_ready` is high for exactly one `clk` cycle: the last cycle of each frame, while `bclk_o` is high. A pair offered with `pair_valid` in that cycle is sent in the next frame. Without `pair_valid`, the next frame repeats the previous pair.
- R10: `fmt_sel` and `wlen_sel` are sampled only in the `pair_ready` cycle. A change during a frame does not alter that frame.
- R11: While reset is low, `bclk_o` = 0, `wclk_o` = 1, `sdata_o` = 0 and `pair_ready` = 0. The first frame after reset is left-justified, 24-bit, with zero samples, whatever the select inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Framing code, sampled at the frame boundary |
| wlen_sel | input | 2 | Word-length code, sampled at the frame boundary |
| left_in | input | 24 | Left sample, MSB at bit 23 |
| right_in | input | 24 | Right sample, MSB at bit 23 |
| pair_valid | input | 1 | Source offers a stereo pair |
| pair_ready | output | 1 | Frame boundary; the offered pair is taken |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The checker watches the edge discipline on every cycle:
- data and word clock move only with a falling bit clock;
- the ready strobe is one cycle wide and falls in a bit-clock high phase;
- every bit-clock period matches either the divided rate, the reference rate, or the single mixed period at a format switch.

The directed scenarios are the only way to show the bit placement for each framing and word-length code, including truncation and zero padding. They also show that the select inputs are deferred to the boundary, that an unoffered pair is repeated, and what the first frame after reset contains.

// File: rtl/audio_tx_pkg.sv
// Package: shared constants, framing codes and word-length decode for the
// serial audio transmitter. Assumes MSB-aligned 24-bit input samples.
package audio_tx_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
    localparam int POS_W      = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'b00,
        FMT_I2S   = 2'b01,
        FMT_TDM   = 2'b10,
        FMT_RIGHT = 2'b11
    } frame_fmt_e;

    // Number of sample bits carried for a word-length code.
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/atx_bclk_gen.sv
// Bit-clock generator: divides clk into bit periods. Each bit is low for
// half_n cycles then high for half_n cycles, where half_n is 1 in TDM and
// HALF otherwise. Assumes the tdm select only changes when bit_end is high.
module atx_bclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tdm,
    output logic bclk,
    output logic bit_end
);
    localparam int PW = (HALF > 1) ? $clog2(2 * HALF) : 1;

    logic [PW-1:0] ph;
    logic [PW:0]   half_v;
    logic [PW:0]   last_v;

    // Pick the half-period length for the active framing.
    always_comb begin
        half_v  = tdm ? (PW+1)'(1) : (PW+1)'(HALF);
        last_v  = (half_v << 1) - (PW+1)'(1);
        bclk    = ({1'b0, ph} >= half_v);
        bit_end = ({1'b0, ph} == last_v);
    end

    // Phase counter within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= '0;
        else if (bit_end) ph <= '0;
        else              ph <= ph + 1'b1;
    end

endmodule

// File: rtl/atx_frame_seq.sv
// Frame sequencer: counts the 64 bits of a frame and raises ready in the
// last cycle of the frame. At that boundary it latches the framing code,
// the word-length code and, when valid, a new stereo pair. Assumes
// bit_end marks the final clk cycle of each bit.
module atx_frame_seq
    import audio_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_end,
    input  logic [1:0]           fmt_sel,
    input  logic [1:0]           wlen_sel,
    input  logic [SAMPLE_W-1:0]  left_in,
    input  logic [SAMPLE_W-1:0]  right_in,
    input  logic                 pair_valid,
    output logic                 ready,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output frame_fmt_e           act_fmt,
    output logic [1:0]           act_wlen,
    output logic [SAMPLE_W-1:0]  act_left,
    output logic [SAMPLE_W-1:0]  act_right
);
    // Boundary strobe: last cycle of the last bit.
    always_comb ready = bit_end && (bit_idx == BIT_IDX_W'(FRAME_BITS - 1));

    // Bit position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_idx <= '0;
        else if (ready)   bit_idx <= '0;
        else if (bit_end) bit_idx <= bit_idx + 1'b1;
    end

    // Settings latched only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_fmt  <= FMT_LEFT;
            act_wlen <= 2'b00;
        end else if (ready) begin
            act_fmt  <= frame_fmt_e'(fmt_sel);
            act_wlen <= wlen_sel;
        end
    end

    // Stereo pair capture on the ready/valid handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_left  <= '0;
            act_right <= '0;
        end else if (ready && pair_valid) begin
            act_left  <= left_in;
            act_right <= right_in;
        end
    end

endmodule

// File: rtl/atx_slot_mux.sv
// Slot multiplexer: from the frame bit position and the active settings,
// decodes the word-clock level and the serial data bit. Places the
// truncated sample in its slot per framing and zero-fills the rest.
module atx_slot_mux
    import audio_tx_pkg::*;
(
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  frame_fmt_e           fmt,
    input  logic [1:0]           wlen,
    input  logic [SAMPLE_W-1:0]  left_s,
    input  logic [SAMPLE_W-1:0]  right_s,
    output logic                 wclk,
    output logic                 sdata
);
    logic                slot;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] shifted;
    int                  nbits;
    int                  idx;

    // Split the frame position into a channel slot and a bit within it.
    always_comb begin
        slot = bit_idx[BIT_IDX_W-1];
        pos  = bit_idx[POS_W-1:0];
        word = slot ? right_s : left_s;
    end

    // Word clock level: I2S inverts the channel polarity.
    always_comb wclk = (fmt == FMT_I2S) ? slot : ~slot;

    // Map slot position to a sample bit index, then pick that bit or zero.
    always_comb begin
        nbits = word_bits(wlen);
        case (fmt)
            FMT_I2S:   idx = int'(pos) - 1;
            FMT_RIGHT: idx = int'(pos) - (SLOT_BITS - nbits);
            default:   idx = int'(pos);
        endcase
        shifted = word << idx[POS_W-1:0];
        sdata   = (idx >= 0 && idx < nbits) ? shifted[SAMPLE_W-1] : 1'b0;
    end

endmodule

// File: rtl/audio_serial_tx.sv
// Top: two-channel master-mode serial audio transmitter. clk is twice the
// reference clock; TDM bit clock equals the reference, other framings
// divide further by BCLK_HALF. Outputs are decoded from registered state.
module audio_serial_tx
    import audio_tx_pkg::*;
#(
    parameter int BCLK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                pair_valid,
    output logic                pair_ready,
    output logic                bclk_o,
    output logic                wclk_o,
    output logic                sdata_o
);
    logic                 bit_end;
    logic [BIT_IDX_W-1:0] bit_idx;
    frame_fmt_e           act_fmt;
    logic [1:0]           act_wlen;
    logic [SAMPLE_W-1:0]  act_left;
    logic [SAMPLE_W-1:0]  act_right;

    atx_bclk_gen #(.HALF(BCLK_HALF)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tdm     (act_fmt == FMT_TDM),
        .bclk    (bclk_o),
        .bit_end (bit_end)
    );

    atx_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_end    (bit_end),
        .fmt_sel    (fmt_sel),
        .wlen_sel   (wlen_sel),
        .left_in    (left_in),
        .right_in   (right_in),
        .pair_valid (pair_valid),
        .ready      (pair_ready),
        .bit_idx    (bit_idx),
        .act_fmt    (act_fmt),
        .act_wlen   (act_wlen),
        .act_left   (act_left),
        .act_right  (act_right)
    );

    atx_slot_mux u_mux (
        .bit_idx (bit_idx),
        .fmt     (act_fmt),
        .wlen    (act_wlen),
        .left_s  (act_left),
        .right_s (act_right),
        .wclk    (wclk_o),
        .sdata   (sdata_o)
    );

endmodule

// File: rtl/audio_serial_tx_chk.sv
// Checker: port-level timing properties of the transmitter. Tracks the
// number of clk cycles between bit-clock rising edges with a counter.
module audio_serial_tx_chk #(
    parameter int BCLK_HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bclk_o,
    input logic wclk_o,
    input logic sdata_o,
    input logic pair_ready
);
    localparam int GW = $clog2(2 * BCLK_HALF + 2) + 1;

    logic          bclk_q;
    logic          seen_rise;
    logic [GW-1:0] gap;
    logic          rise;

    always_comb rise = bclk_o && !bclk_q;

    // Cycles elapsed since the previous bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            bclk_q <= bclk_o;
            if (rise) begin
                seen_rise <= 1'b1;
                gap       <= GW'(1);
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R8
    stable_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o == $past(bclk_o)) |-> ($stable(sdata_o) && $stable(wclk_o)));

    // R1
    wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wclk_o) |-> $fell(bclk_o));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |=> !pair_ready);

    // R9
    ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> bclk_o);

    // R6
    bclk_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_rise) |-> (gap == GW'(2) || gap == GW'(2 * BCLK_HALF)
                                 || gap == GW'(BCLK_HALF + 1)));

endmodule

bind audio_serial_tx audio_serial_tx_chk #(.BCLK_HALF(BCLK_HALF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_o     (bclk_o),
    .wclk_o     (wclk_o),
    .sdata_o    (sdata_o),
    .pair_ready (pair_ready)
);

// File: tb/audio_serial_tx_tb.sv
// Directed bench: a monitor captures each frame's bits at bit-clock rises;
// one task per scenario offers a pair and compares the captured frame.
module audio_serial_tx_tb;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  wlen_sel = 2'b00;
    logic [23:0] left_in = '0;
    logic [23:0] right_in = '0;
    logic        pair_valid = 1'b0;
    logic        pair_ready, bclk_o, wclk_o, sdata_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    audio_serial_tx #(.BCLK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
        .left_in(left_in), .right_in(right_in), .pair_valid(pair_valid),
        .pair_ready(pair_ready), .bclk_o(bclk_o), .wclk_o(wclk_o),
        .sdata_o(sdata_o)
    );

    // Frame capture at each bit-clock rise, sampled on the falling clk edge.
    logic cap_sd [64];
    logic cap_wc [64];
    int   cap_gap [64];
    int   n_rise = 0;
    int   frames_done = 0;
    int   gap_cnt = 0;
    logic prev_b = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_b  = 1'b0;
            gap_cnt = 0;
        end else begin
            gap_cnt++;
            if (bclk_o && !prev_b) begin
                cap_sd[n_rise % 64]  = sdata_o;
                cap_wc[n_rise % 64]  = wclk_o;
                cap_gap[n_rise % 64] = gap_cnt;
                gap_cnt = 0;
                n_rise++;
                if (n_rise % 64 == 0) frames_done++;
            end
            prev_b = bclk_o;
        end
    end

    function automatic logic exp_sd(input logic [1:0] f, input logic [1:0] w,
                                    input logic [23:0] l, input logic [23:0] r,
                                    input int b);
        int          nb;
        logic [31:0] sv;
        nb = (w == 2'b00) ? 24 : (w == 2'b01) ? 20 : (w == 2'b10) ? 18 : 16;
        sv = {8'd0, (b < 32) ? l : r} >> (24 - nb);
        if (f == 2'b00 || f == 2'b10) sv = sv << (32 - nb);
        else if (f == 2'b01)          sv = sv << (31 - nb);
        return sv[31 - (b % 32)];
    endfunction

    function automatic logic exp_wc(input logic [1:0] f, input int b);
        return (f == 2'b01) ? (b >= 32) : (b < 32);
    endfunction

    task automatic check_frame(input string tag, input logic [1:0] f,
                               input logic [1:0] w, input logic [23:0] l,
                               input logic [23:0] r);
        bit sd_ok = 1'b1, wc_ok = 1'b1, gp_ok = 1'b1;
        int egap = (f == 2'b10) ? 2 : 2 * HALF;
        for (int b = 0; b < 64; b++) begin
            if (sd_ok && cap_sd[b] !== exp_sd(f, w, l, r, b)) begin
                sd_ok = 1'b0;
                $display("FAIL %s data bit %0d: actual %b expected %b",
                         tag, b, cap_sd[b], exp_sd(f, w, l, r, b));
            end
            if (wc_ok && cap_wc[b] !== exp_wc(f, b)) begin
                wc_ok = 1'b0;
                $display("FAIL %s R1 word clock bit %0d: actual %b expected %b",
                         tag, b, cap_wc[b], exp_wc(f, b));
            end
            if (gp_ok && b > 0 && cap_gap[b] != egap) begin
                gp_ok = 1'b0;
                $display("FAIL %s R5/R6 bclk period bit %0d: actual %0d expected %0d",
                         tag, b, cap_gap[b], egap);
            end
        end
        n_chk += 3;
        n_bad += (!sd_ok) + (!wc_ok) + (!gp_ok);
    endtask

    // Present settings and a pair; hold valid through one ready strobe (R9).
    task automatic offer(input logic [1:0] f, input logic [1:0] w,
                         input logic [23:0] l, input logic [23:0] r);
        fmt_sel = f; wlen_sel = w; left_in = l; right_in = r;
        pair_valid = 1'b1;
        while (!pair_ready) @(negedge clk);
        @(negedge clk);
        pair_valid = 1'b0;
        n_chk++;
        if (pair_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 ready width: actual %b expected 0", pair_ready);
        end
    endtask

    task automatic wait_check(input string tag, input logic [1:0] f,
                              input logic [1:0] w, input logic [23:0] l,
                              input logic [23:0] r);
        int tgt = frames_done + 1;
        wait (frames_done == tgt);
        check_frame(tag, f, w, l, r);
    endtask

    task automatic run_frame(input string tag, input logic [1:0] f,
                             input logic [1:0] w, input logic [23:0] l,
                             input logic [23:0] r);
        offer(f, w, l, r);
        wait_check(tag, f, w, l, r);
    endtask

    // R11: reset levels, and a default first frame despite a non-zero select.
    task automatic t_reset();
        fmt_sel = 2'b01; wlen_sel = 2'b11;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        n_chk++;
        if ({bclk_o, wclk_o, sdata_o, pair_ready} !== 4'b0100) begin
            n_bad++;
            $display("FAIL R11 reset outputs: actual %b expected 0100",
                     {bclk_o, wclk_o, sdata_o, pair_ready});
        end
        rst_n = 1'b1;
        wait_check("R11 first frame", 2'b00, 2'b00, 24'h0, 24'h0);
    endtask

    // R9: no valid at the boundary, so the last pair repeats.
    task automatic t_hold(input logic [1:0] f, input logic [1:0] w,
                          input logic [23:0] l, input logic [23:0] r);
        wait_check("R9 held pair", f, w, l, r);
    endtask

    // R10: a select change mid-frame waits for the next boundary.
    task automatic t_midchange();
        offer(2'b00, 2'b00, 24'h9E3C71, 24'h2B84D5);
        while (n_rise % 64 != 20) @(negedge clk);
        fmt_sel = 2'b01; wlen_sel = 2'b11;
        wait_check("R10 old settings", 2'b00, 2'b00, 24'h9E3C71, 24'h2B84D5);
        wait_check("R10 new settings", 2'b01, 2'b11, 24'h9E3C71, 24'h2B84D5);
    endtask

    initial begin
        t_reset();
        run_frame("R2 left-justified 24", 2'b00, 2'b00, 24'hC35A69, 24'h3C96A5);
        run_frame("R3 I2S 20 R7",         2'b01, 2'b01, 24'hF0E1D3, 24'h8A5F17);
        run_frame("R4 right-justified 16 R7", 2'b11, 2'b11, 24'hB7C2E9, 24'h4D1A8F);
        run_frame("R4 right-justified 18 R7", 2'b11, 2'b10, 24'hFFFFC1, 24'h80007F);
        run_frame("R5 TDM 24",            2'b10, 2'b00, 24'hA1B2C3, 24'h5D6E7F);
        run_frame("R5 TDM 18 R7",         2'b10, 2'b10, 24'h7FC0FF, 24'hC0FFEE);
        run_frame("R6 left-justified 20 after TDM", 2'b00, 2'b01, 24'h13579B, 24'hECA864);
        t_hold(2'b00, 2'b01, 24'h13579B, 24'hECA864);
        t_midchange();
        run_frame("R3 I2S 24",            2'b01, 2'b00, 24'h800001, 24'h7FFFFE);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20ns);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule